// File: doc/BRIEF.md
# Byte-Parallel Serial Link Transmitter

This block takes one byte per character period from a parallel source and turns it into a serial line stream. Each byte is encoded as a DC-balanced 8b/10b code, and the ten code bits are shifted out one per bit clock. A bit clock and a byte clock are both supplied. The byte clock runs at one tenth of the bit-clock rate and is sampled synchronously in the bit-clock domain. Each rising edge of the byte clock opens a new character period.

There are two active-low capture enables. `take_n` also drives a read strobe, `rd_n`, which can pop the next word from an upstream FIFO. `load_n` captures the byte without any strobe. `is_ctrl` asks for the byte to be sent as a special (K) character. `force_bad` replaces the character with an invalid line symbol. In a period where neither enable is active, the block sends the comma sync character K28.5 so that the far end stays framed.

Top module: `byte_serial_tx`

## Requirements
- R1: Inputs `din`, `is_ctrl` and `force_bad` are captured only on the bit-clock edge where a rising byte clock is first seen, and only if `take_n` or `load_n` is low at that edge. Changes at any other time have no effect.
- R2: If both enables are high at the period edge, the block sends K28.5: abcdeifghj = 0011111010 when the running disparity is negative and 1100000101 when it is positive. The input byte and control bits are ignored in that period.
- R3: While `take_n` is low, `rd_n` is low during phases 0 to 5 of each period and high during phases 6 to 9. Phase 0 is the bit clock that follows the period edge. While `take_n` is high, `rd_n` stays high.
- R4: With `is_ctrl` low, a byte HGFEDCBA is sent as the standard 8b/10b data code D.x.y. Here x = bits 4:0 and y = bits 7:5, and the code is written abcdei fghj. The alternate y=7 sub-block is used for x = 17, 18, 20 at negative disparity and for x = 11, 13, 14 at positive disparity.
- R5: With `is_ctrl` high, the bytes 1C, 3C, 5C, 7C, 9C, BC, DC, FC, F7, FB, FD and FE (hex) are sent as the K codes K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. Any other byte is sent as the violation symbol.
- R6: A captured `force_bad` sends the violation symbol abcdeifghj = 1111100000 and leaves the running disparity unchanged.
- R7: Running disparity is negative after reset. It flips after every code with four or six ones. The cumulative disparity of the line never leaves ±1.
- R8: Code bits leave on `ser_o` in the order a, b, c, d, e, i, f, g, h, j, one per bit clock, ten per period.
- R9: A character captured at a period edge starts leaving `ser_o` 20 bit clocks later. Its bit a is present after the period edge two periods on.
- R10: During and after reset, `ser_o` is low and `rd_n` is high. The first period after reset sends ten zero bits. The second period sends K28.5 at negative disparity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| byte_clk | input | 1 | Byte clock, synchronous to clk_bit, period of ten bit clocks |
| take_n | input | 1 | Active-low capture enable that also produces the read strobe |
| load_n | input | 1 | Active-low capture enable without read strobe |
| din | input | 8 | Byte to send |
| is_ctrl | input | 1 | Encode `din` as a special character |
| force_bad | input | 1 | Send the violation symbol for this character |
| rd_n | output | 1 | Active-low FIFO read strobe, 6 bit times low and 4 high per period |
| ser_o | output | 1 | Serial line output, bit a first |

## Verification
The embedded properties assume that `byte_clk` is a clean signal synchronous to `clk_bit`, with exactly one rising edge per ten bit clocks. They also assume that `din` and the control inputs are steady on the edge where that rise is seen. The bench drives every input on the falling edge of the bit clock. It raises `byte_clk` at the start of each ten-cycle period and lowers it after five cycles. This keeps the phase counter from ever saturating during normal traffic. One period deliberately changes `din` in mid-period, away from the capture edge, to show that only the edge sample counts.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
  localparam int BYTE_W     = 8;
  localparam int CODE_W     = 10;
  localparam int PERIOD     = 10;
  localparam int STROBE_LOW = 6;
  localparam int PH_W       = $clog2(PERIOD);

  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hBC;
  // violation symbol, a first (msb) and as sent (lsb first)
  localparam logic [CODE_W-1:0] VIOL_MSB = 10'b1111100000;
  localparam logic [CODE_W-1:0] VIOL_LSB = 10'b0000011111;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              is_k;
    logic              bad;
  } lat_t;

  // 6-bit sub-block abcdei for negative running disparity
  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
      5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
    endcase
  endfunction

  // 4-bit sub-block fghj for negative disparity (primary y=7)
  function automatic logic [3:0] four_neg(input logic [2:0] y);
    case (y)
      3'd0: four_neg = 4'b1011;  3'd1: four_neg = 4'b1001;
      3'd2: four_neg = 4'b0101;  3'd3: four_neg = 4'b1100;
      3'd4: four_neg = 4'b1101;  3'd5: four_neg = 4'b1010;
      3'd6: four_neg = 4'b0110;  default: four_neg = 4'b1110;
    endcase
  endfunction

  function automatic logic k_ok(input logic [BYTE_W-1:0] d);
    k_ok = (d[4:0] == 5'd28) || (d == 8'hF7) || (d == 8'hFB) ||
           (d == 8'hFD) || (d == 8'hFE);
  endfunction
endpackage

// File: rtl/sertx_timer.sv
`timescale 1ns/1ps
module sertx_timer
  import sertx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic byte_clk,
  input  logic take_n,
  output logic tick,
  output logic rd_n
);
  logic            bclk_q;
  logic [PH_W-1:0] ph_q, ph_nxt;

  assign tick = byte_clk && !bclk_q;

  always_comb begin
    if (tick)                          ph_nxt = '0;
    else if (ph_q == PH_W'(PERIOD-1))  ph_nxt = ph_q;
    else                               ph_nxt = ph_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      ph_q   <= PH_W'(PERIOD-1);
      rd_n   <= 1'b1;
    end else begin
      bclk_q <= byte_clk;
      ph_q   <= ph_nxt;
      rd_n   <= !(!take_n && (ph_nxt < PH_W'(STROBE_LOW)));
    end
  end

  // R3: strobe high in the last phases of every period
  a_r3_late_high: assert property (@(posedge clk) disable iff (rst)
    (ph_q >= PH_W'(STROBE_LOW)) |-> rd_n);
  // R3: strobe stays high while the strobe enable is inactive
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    $past(take_n) |-> rd_n);
  // R3: strobe low in the early phases while enabled
  a_r3_early_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(take_n) && ph_q < PH_W'(STROBE_LOW)) |-> !rd_n);
endmodule

// File: rtl/sertx_enc.sv
`timescale 1ns/1ps
module sertx_enc
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  lat_t              lat,
  output logic [CODE_W-1:0] code_q
);
  logic              rd_q, rd_mid, rd_new, rd_nxt;
  logic [4:0]        x;
  logic [2:0]        y;
  logic              k28, un6, un4, alt, viol;
  logic [5:0]        s6, c6;
  logic [3:0]        s4, c4;
  logic [CODE_W-1:0] msb, code_lsb;

  always_comb begin
    x      = lat.data[4:0];
    y      = lat.data[7:5];
    k28    = lat.is_k && (x == 5'd28);
    s6     = k28 ? 6'b001111 : six_neg(x);
    un6    = ($countones(s6) != 3);
    c6     = (rd_q && (un6 || (!k28 && x == 5'd7))) ? ~s6 : s6;
    rd_mid = rd_q ^ un6;
    alt    = (y == 3'd7) && (lat.is_k ||
             (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
             ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
    s4     = alt ? 4'b0111 : four_neg(y);
    un4    = ($countones(s4) != 2);
    if (k28 && !un4 && y != 3'd3) c4 = rd_mid ? s4 : ~s4;
    else                          c4 = (rd_mid && (un4 || y == 3'd3)) ? ~s4 : s4;
    rd_new = rd_mid ^ un4;
    viol   = lat.bad || (lat.is_k && !k_ok(lat.data));
    msb    = viol ? VIOL_MSB : {c6, c4};
    rd_nxt = viol ? rd_q : rd_new;
    for (int i = 0; i < CODE_W; i++) code_lsb[i] = msb[CODE_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      rd_q   <= 1'b0;
    end else if (tick) begin
      code_q <= code_lsb;
      rd_q   <= rd_nxt;
    end
  end

  // R7: every code sent is balanced or off by two
  a_r7_bounded: assert property (@(posedge clk) disable iff (rst)
    (code_q != '0) |-> ($countones(code_q) >= 4 && $countones(code_q) <= 6));
  // R7: a heavy code leaves positive disparity, a light one negative
  a_r7_heavy_pos: assert property (@(posedge clk) disable iff (rst)
    ($countones(code_q) == 6) |-> rd_q);
  a_r7_light_neg: assert property (@(posedge clk) disable iff (rst)
    (code_q != '0 && $countones(code_q) == 4) |-> !rd_q);
  // R6: a forced violation yields the fixed symbol and keeps disparity
  a_r6_viol: assert property (@(posedge clk) disable iff (rst)
    (tick && lat.bad) |=> (code_q == VIOL_LSB) && $stable(rd_q));
endmodule

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
module sertx_shift
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              ser_o
);
  logic [CODE_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (tick) sh_q <= code;
    else           sh_q <= {1'b0, sh_q[CODE_W-1:1]};
  end

  assign ser_o = sh_q[0];

  // R8: one bit per bit clock, lowest code bit first
  a_r8_shift: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (ser_o == $past(sh_q[1])));
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    tick |=> (ser_o == $past(code[0])));
endmodule

// File: rtl/byte_serial_tx.sv
`timescale 1ns/1ps
module byte_serial_tx
  import sertx_pkg::*;
(
  input  logic              clk_bit,
  input  logic              rst,
  input  logic              byte_clk,
  input  logic              take_n,
  input  logic              load_n,
  input  logic [BYTE_W-1:0] din,
  input  logic              is_ctrl,
  input  logic              force_bad,
  output logic              rd_n,
  output logic              ser_o
);
  logic              tick, cap;
  lat_t              lat_q, idle_c, in_c;
  logic [CODE_W-1:0] code_q;

  assign cap    = !take_n || !load_n;
  assign idle_c = '{data: SYNC_BYTE, is_k: 1'b1, bad: 1'b0};
  assign in_c   = '{data: din, is_k: is_ctrl, bad: force_bad};

  sertx_timer u_timer (
    .clk(clk_bit), .rst(rst), .byte_clk(byte_clk), .take_n(take_n),
    .tick(tick), .rd_n(rd_n)
  );

  always_ff @(posedge clk_bit) begin
    if (rst)       lat_q <= idle_c;
    else if (tick) lat_q <= cap ? in_c : idle_c;
  end

  sertx_enc u_enc (
    .clk(clk_bit), .rst(rst), .tick(tick), .lat(lat_q), .code_q(code_q)
  );

  sertx_shift u_shift (
    .clk(clk_bit), .rst(rst), .tick(tick), .code(code_q), .ser_o(ser_o)
  );

  // R1: the latch moves only at a period edge
  a_r1_hold: assert property (@(posedge clk_bit) disable iff (rst)
    !tick |=> $stable(lat_q));
  a_r1_capture: assert property (@(posedge clk_bit) disable iff (rst)
    (tick && !load_n) |=> (lat_q.data == $past(din)));
  // R2: no enable at the edge loads the sync character
  a_r2_idle: assert property (@(posedge clk_bit) disable iff (rst)
    (tick && take_n && load_n) |=>
      (lat_q.data == SYNC_BYTE && lat_q.is_k && !lat_q.bad));
endmodule

// File: tb/byte_serial_tx_bench.sv
`timescale 1ns/1ps
module byte_serial_tx_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 17;
  localparam logic [9:0] K285M = 10'b0011111010;
  localparam logic [9:0] K285P = 10'b1100000101;
  localparam logic [9:0] VIOL  = 10'b1111100000;

  // {take_n, load_n, ctrl, bad, data[8], code_neg[10], code_pos[10]}; codes abcdeifghj
  localparam logic [31:0] VEC [NV] = '{
    {4'b0100, 8'h00, 10'b1001110100, 10'b0110001011},  // D.0.0
    {4'b0100, 8'hB5, 10'b1010101010, 10'b1010101010},  // D.21.5
    {4'b1010, 8'hBC, K285M,          K285P},           // K28.5
    {4'b0000, 8'hFF, 10'b1010110001, 10'b0101001110},  // D.31.7 both enables
    {4'b0100, 8'hF1, 10'b1000110111, 10'b1000110001},  // D.17.7
    {4'b1000, 8'hEB, 10'b1101001110, 10'b1101001000},  // D.11.7
    {4'b0100, 8'h67, 10'b1110001100, 10'b0001110011},  // D.7.3
    {4'b0110, 8'h1C, 10'b0011110100, 10'b1100001011},  // K28.0
    {4'b1010, 8'hF7, 10'b1110101000, 10'b0001010111},  // K23.7
    {4'b0110, 8'h00, VIOL,           VIOL},            // invalid K
    {4'b0101, 8'h55, VIOL,           VIOL},            // forced violation
    {4'b1100, 8'h4A, K285M,          K285P},           // idle
    {4'b1111, 8'h00, K285M,          K285P},           // idle, controls ignored
    {4'b0100, 8'h4A, 10'b0101010101, 10'b0101010101},  // D.10.2
    {4'b1010, 8'hFC, 10'b0011111000, 10'b1100000111},  // K28.7
    {4'b0100, 8'h84, 10'b1101010010, 10'b0010101101},  // D.4.4
    {4'b0110, 8'hFB, 10'b1101101000, 10'b0010010111}   // K27.7
  };

  logic clk_bit = 1'b0, rst, byte_clk, take_n, load_n, is_ctrl, force_bad;
  logic [7:0] din;
  logic rd_n, ser_o;

  int n_chk = 0, n_fail = 0, rp = 0, wp = 0, cum = -1;
  logic rdm = 1'b0;
  logic [9:0] exp_w [64];
  bit         exp_d [64];
  string      exp_t [64];

  byte_serial_tx u_byte_serial_tx (
    .clk_bit(clk_bit), .rst(rst), .byte_clk(byte_clk), .take_n(take_n),
    .load_n(load_n), .din(din), .is_ctrl(is_ctrl), .force_bad(force_bad),
    .rd_n(rd_n), .ser_o(ser_o)
  );

  always #(CLK_P/2) clk_bit = ~clk_bit;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  task automatic push(input logic [9:0] w, input bit dchk, input string tag);
    exp_w[wp] = w; exp_d[wp] = dchk; exp_t[wp] = tag; wp++;
  endtask

  // one character period, starting at a falling edge
  task automatic run_period(input logic [31:0] v, input bit glitch);
    logic [9:0] rx, rdn, sexp, code;
    string tag;
    byte_clk = 1'b1;
    take_n = v[31]; load_n = v[30]; is_ctrl = v[29]; force_bad = v[28];
    din = v[27:20];
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_bit);
      rx[9-i] = ser_o;          // R8: bit a first
      rdn[i]  = rd_n;
      if (i == 4) byte_clk = 1'b0;
      if (glitch && i == 5) din = ~din;   // R1: off-edge change
    end
    sexp = v[31] ? 10'h3FF : 10'b1111000000;
    check(rdn == sexp, "R3 strobe", 32'(rdn), 32'(sexp));
    check(rx == exp_w[rp], {exp_t[rp], " R8 R9 word"}, 32'(rx), 32'(exp_w[rp]));
    if (exp_d[rp]) begin
      cum += 2 * $countones(rx) - 10;
      check(cum == 1 || cum == -1, "R7 disparity", 32'(cum), 32'd1);
    end
    rp++;
    // R7: bench tracks disparity from the expected code weights
    code = rdm ? v[9:0] : v[19:10];
    if (glitch)              tag = "R1";
    else if (v[31] && v[30]) tag = "R2";
    else if (v[28])          tag = "R6";
    else if (v[29])          tag = "R5";
    else                     tag = "R4";
    push(code, 1'b1, tag);
    if ($countones(code) != 5) rdm = ~rdm;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; byte_clk = 1'b0; take_n = 1'b1; load_n = 1'b1;
    is_ctrl = 1'b0; force_bad = 1'b0; din = 8'h00;
    repeat (4) @(negedge clk_bit);
    check(ser_o == 1'b0, "R10 reset ser_o", 32'(ser_o), 32'd0);
    check(rd_n == 1'b1, "R10 reset rd_n", 32'(rd_n), 32'd1);
    rst = 1'b0;
    push(10'b0, 1'b0, "R10");
    push(K285M, 1'b1, "R10");
    rdm = 1'b1;
    for (int k = 0; k < NV; k++) run_period(VEC[k], 1'b0);
    run_period({4'b1000, 8'h4A, 10'b0101010101, 10'b0101010101}, 1'b1);
    run_period({4'b1100, 8'h00, K285M, K285P}, 1'b0);
    run_period({4'b1100, 8'h00, K285M, K285P}, 1'b0);
    run_period({4'b1100, 8'h00, K285M, K285P}, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule